// File: doc/BRIEF.md
# External Interrupt Edge Conditioner

This block sits between the raw interrupt pins of a small microcontroller and its interrupt logic. It watches five request sources and turns qualifying pin transitions into sticky request flags. Three sources are vectored interrupts: a filtered line with a selectable edge, a plain line with a selectable edge, and a line that reacts to both edges. Two sources are quasi-interrupts that only set flags: a line that reacts to rising edges, and a group of key-scan lines that share one flag and react to falling edges.

Every unfiltered pin passes through a two-flop synchroniser before edge detection. The filtered line also passes through a synchroniser, then through a noise filter that is built as a two-state machine. In `FLT_HOLD` the synchronised input matches the accepted level. A difference moves the machine to `FLT_QUAL` ("start"). In `FLT_QUAL` it counts qualifying ticks. If the input returns to the accepted level, the machine goes back to `FLT_HOLD` ("abort") and the count is dropped. If the count reaches the selected width, the accepted level flips and the machine goes back to `FLT_HOLD` ("accept"). Otherwise it stays in `FLT_QUAL` ("count"). There are two widths. The short width is two ticks of the CPU-cycle strobe. The long width is 128 consecutive system-clock samples. Software clears a flag by pulsing its clear bit. A new edge that arrives in the same cycle as a clear wins over the clear.

Top module: `ext_irq_cond`

## Requirements
- R1: While reset is active, and afterwards until a pin changes, all five flags and all three request outputs are 0. The configuration resets to 0, which means: rising edges on both selectable lines, the short filter width, and all enables off.
- R2: Flag bit 1 follows `pin_pick`. When configuration bit 1 is 0, a rising edge sets the flag and a falling edge is ignored. When the bit is 1, the roles swap. The flag is set on the third rising clock edge after the pin changes.
- R3: Flag bit 2 follows `pin_both`. Both rising and falling edges set it, three clock edges after the pin changes.
- R4: Flag bit 3 follows `pin_up`. Only rising edges set it. Falling edges leave it unchanged.
- R5: Flag bit 4 is set by a falling edge on any bit of `key_pins`, including several at once. Rising edges on those pins have no effect.
- R6: Flag bit 0 is fed through the filter. When configuration bit 2 is 1 (long width), a level on `pin_filt` held for 127 clocks is ignored. A level held for 128 clocks is accepted, and its flag appears at the 131st clock edge after the pin change.
- R7: When configuration bit 2 is 0 (short width), the change on `pin_filt` is accepted only after it is seen on two `cpu_tick` strobes in a row. A one-clock pulse is ignored when the strobe period is four clocks.
- R8: Configuration bit 0 chooses the edge of the filtered level that sets flag bit 0: 0 means rising, 1 means falling.
- R9: A 1 on `clr_pulse[i]` clears flag i at the next clock edge. Flags whose clear bit is 0 keep their value.
- R10: When an edge sets flag i in the same clock edge that `clr_pulse[i]` is 1, the flag ends up 1.
- R11: `irq_req[i]` is 1 exactly when flag i and enable bit i are both 1, for i = 0 to 2. The enables are configuration bits 5:3. The quasi flags (bits 3 and 4) drive no request.
- R12: The configuration register loads `cfg_data` on the clock edge where `cfg_wr` is 1. The bit layout is [0] filtered-line falling, [1] pick-line falling, [2] long width, [5:3] enables. New values act from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_tick | input | 1 | One-clock strobe, once per CPU cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 6 | Configuration value (layout in R12) |
| pin_filt | input | 1 | Raw filtered vectored line |
| pin_pick | input | 1 | Raw vectored line with selectable edge |
| pin_both | input | 1 | Raw vectored line, both edges |
| pin_up | input | 1 | Raw quasi line, rising edges |
| key_pins | input | NUM_KEY | Raw key-scan lines, falling edges |
| clr_pulse | input | 5 | Write-one clear, one bit per flag |
| flags | output | 5 | Request flags: [0] filtered, [1] pick, [2] both, [3] up, [4] keys |
| irq_req | output | 3 | Enabled vectored requests |

## Verification
For an unfiltered pin, the flag is due on the third rising edge after the pin changes: two synchroniser stages, then the flag register. For the filtered line in long mode, the flag is due on edge 131. A clear and a configuration write each act on the next edge, and `irq_req` follows the flags with no added cycle. The bench changes inputs on falling edges and counts rising edges to each due point. It checks the unfiltered flags exactly three edges later. For long mode it checks one edge before and at the due edge. In short mode the strobe phase is free, so the check waits well past the worst case.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_PICK = 2'd3
    } edge_mode_e;

    // flag positions
    localparam int SRC_FILT = 0;
    localparam int SRC_PICK = 1;
    localparam int SRC_BOTH = 2;
    localparam int SRC_UP   = 3;
    localparam int SRC_KEY  = 4;
    localparam int NUM_SRC  = 5;
    localparam int NUM_VEC  = 3;

    // positions in the unfiltered raw vector
    localparam int RAW_PICK = 0;
    localparam int RAW_BOTH = 1;
    localparam int RAW_UP   = 2;
    localparam int RAW_KEY0 = 3;

    // configuration fields
    localparam int CFG_FALL_FILT = 0;
    localparam int CFG_FALL_PICK = 1;
    localparam int CFG_LONG      = 2;
    localparam int CFG_EN_LSB    = 3;
    localparam int CFG_W         = CFG_EN_LSB + NUM_VEC;

    function automatic edge_mode_e raw_mode(input int idx);
        if (idx == RAW_PICK)      return EDGE_PICK;
        else if (idx == RAW_BOTH) return EDGE_BOTH;
        else if (idx == RAW_UP)   return EDGE_RISE;
        else                      return EDGE_FALL;
    endfunction

    function automatic logic edge_hit(input edge_mode_e mode, input logic fall_sel,
                                      input logic rise, input logic fall);
        case (mode)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return fall_sel ? fall : rise;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/irq_edge.sv
module irq_edge
    import irq_cond_pkg::*;
#(
    parameter edge_mode_e MODE     = EDGE_RISE,
    parameter logic       PREV_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic fall_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PREV_RST;
        else        prev_q <= lvl;
    end

    assign hit = edge_hit(MODE, fall_sel, lvl & ~prev_q, ~lvl & prev_q);
endmodule

// File: rtl/irq_filter.sv
module irq_filter #(
    parameter int SHORT_TICKS = 2,
    parameter int LONG_TICKS  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_tick,
    input  logic long_sel,
    input  logic din,
    output logic lvl
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    typedef enum logic {
        FLT_HOLD = 1'b0,
        FLT_QUAL = 1'b1
    } flt_state_e;

    flt_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             lvl_q, lvl_n;
    logic [CNT_W-1:0] limit;
    logic             tick;

    assign limit = long_sel ? CNT_W'(LONG_TICKS - 1) : CNT_W'(SHORT_TICKS - 1);
    assign tick  = long_sel | cpu_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            lvl_q   <= lvl_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        lvl_n   = lvl_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (din != lvl_q) begin
                    state_n = FLT_QUAL;
                    cnt_n   = tick ? CNT_W'(1) : '0;
                end
            end
            FLT_QUAL: begin
                if (din == lvl_q) begin
                    state_n = FLT_HOLD;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (cnt_q >= limit) begin
                        lvl_n   = ~lvl_q;
                        state_n = FLT_HOLD;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_n = FLT_HOLD;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        lvl = lvl_q;
    end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import irq_cond_pkg::*;
#(
    parameter int SHORT_TICKS = 2,
    parameter int LONG_TICKS  = 128,
    parameter int NUM_KEY     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_tick,
    input  logic               cfg_wr,
    input  logic [5:0]         cfg_data,
    input  logic               pin_filt,
    input  logic               pin_pick,
    input  logic               pin_both,
    input  logic               pin_up,
    input  logic [NUM_KEY-1:0] key_pins,
    input  logic [4:0]         clr_pulse,
    output logic [4:0]         flags,
    output logic [2:0]         irq_req
);
    localparam int NUM_RAW = RAW_KEY0 + NUM_KEY;
    localparam logic [NUM_RAW-1:0] RAW_RST = {{NUM_KEY{1'b1}}, {RAW_KEY0{1'b0}}};

    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_RAW-1:0] raw_pins, raw_sync, raw_hit;
    logic               filt_sync, filt_lvl, filt_hit;
    logic [NUM_SRC-1:0] set_vec, flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_data;
    end

    assign raw_pins = {key_pins, pin_up, pin_both, pin_pick};

    irq_sync #(.W(NUM_RAW), .RST_VAL(RAW_RST)) i_raw_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_pins), .dout(raw_sync)
    );

    irq_sync #(.W(1), .RST_VAL(1'b0)) i_filt_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_filt), .dout(filt_sync)
    );

    irq_filter #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) i_filter (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .long_sel(cfg_q[CFG_LONG]),
        .din(filt_sync), .lvl(filt_lvl)
    );

    irq_edge #(.MODE(EDGE_PICK), .PREV_RST(1'b0)) i_filt_edge (
        .clk(clk), .rst_n(rst_n), .lvl(filt_lvl),
        .fall_sel(cfg_q[CFG_FALL_FILT]), .hit(filt_hit)
    );

    for (genvar g = 0; g < NUM_RAW; g++) begin : g_raw_edge
        irq_edge #(.MODE(raw_mode(g)), .PREV_RST(RAW_RST[g])) i_edge (
            .clk(clk), .rst_n(rst_n), .lvl(raw_sync[g]),
            .fall_sel((g == RAW_PICK) ? cfg_q[CFG_FALL_PICK] : 1'b0),
            .hit(raw_hit[g])
        );
    end

    assign set_vec[SRC_FILT] = filt_hit;
    assign set_vec[SRC_PICK] = raw_hit[RAW_PICK];
    assign set_vec[SRC_BOTH] = raw_hit[RAW_BOTH];
    assign set_vec[SRC_UP]   = raw_hit[RAW_UP];
    assign set_vec[SRC_KEY]  = |raw_hit[NUM_RAW-1:RAW_KEY0];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[s] <= 1'b0;
            else        flag_q[s] <= set_vec[s] | (flag_q[s] & ~clr_pulse[s]);
        end
    end

    assign flags   = flag_q;
    assign irq_req = flag_q[NUM_VEC-1:0] & cfg_q[CFG_EN_LSB +: NUM_VEC];
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk #(
    parameter int NUM_SRC = 5,
    parameter int NUM_VEC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] clr_pulse,
    input logic [NUM_SRC-1:0] set_vec,
    input logic [NUM_VEC-1:0] irq_req,
    input logic               filt_sync,
    input logic               filt_lvl
);
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags) & ~$past(clr_pulse)) & ~flags) == '0)); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_vec) & ~flags) == '0)); // R10

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags & ~$past(flags)) & ~$past(set_vec)) == '0)); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~flags[NUM_VEC-1:0]) == '0)); // R11

    AST_FILT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_lvl != $past(filt_lvl)) |-> ($past(filt_sync) != $past(filt_lvl))); // R6
endmodule

bind ext_irq_cond irq_cond_chk #(.NUM_SRC(5), .NUM_VEC(3)) i_chk (
    .clk(clk), .rst_n(rst_n), .flags(flags), .clr_pulse(clr_pulse),
    .set_vec(set_vec), .irq_req(irq_req), .filt_sync(filt_sync), .filt_lvl(filt_lvl)
);

// File: tb/test_ext_irq_cond.sv
module test_ext_irq_cond;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_data = '0;
    logic       pin_filt = 1'b0;
    logic       pin_pick = 1'b0;
    logic       pin_both = 1'b0;
    logic       pin_up = 1'b0;
    logic [2:0] key_pins = 3'b111;
    logic [4:0] clr_pulse = '0;
    logic [4:0] flags;
    logic [2:0] irq_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ext_irq_cond i_ext_irq_cond (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .pin_filt(pin_filt), .pin_pick(pin_pick), .pin_both(pin_both), .pin_up(pin_up),
        .key_pins(key_pins), .clr_pulse(clr_pulse), .flags(flags), .irq_req(irq_req)
    );

    // CPU strobe: one clock high in every four
    initial begin
        forever begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                cpu_tick = (k == 3);
            end
        end
    end

    // {req[3:0], pins{pick,both,up,key[2:0]}, clr[4:0], expected flags[4:0]}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {4'd1, 6'b000111, 5'b00000, 5'b00000},  // R1 quiet
        {4'd2, 6'b100111, 5'b00000, 5'b00010},  // R2 rising sets
        {4'd2, 6'b000111, 5'b00000, 5'b00010},  // R2 falling ignored
        {4'd3, 6'b010111, 5'b00000, 5'b00110},  // R3 rising
        {4'd9, 6'b010111, 5'b00110, 5'b00000},  // R9 clear two
        {4'd3, 6'b000111, 5'b00000, 5'b00100},  // R3 falling
        {4'd4, 6'b001111, 5'b00000, 5'b01100},  // R4 rising
        {4'd9, 6'b001111, 5'b01000, 5'b00100},  // R9 clear one only
        {4'd4, 6'b000111, 5'b00000, 5'b00100},  // R4 falling ignored
        {4'd5, 6'b000101, 5'b00000, 5'b10100},  // R5 one key falls
        {4'd9, 6'b000101, 5'b10000, 5'b00100},  // R9
        {4'd5, 6'b000111, 5'b00000, 5'b00100},  // R5 key rise ignored
        {4'd5, 6'b000010, 5'b00000, 5'b10100},  // R5 two keys fall
        {4'd9, 6'b000010, 5'b11111, 5'b00000}   // R9 clear all
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // drive pins and clear at a falling edge, clear lasts one clock, sample three edges later
    task automatic step(input logic [5:0] pins, input logic [4:0] clr);
        @(negedge clk);
        {pin_pick, pin_both, pin_up, key_pins} = pins;
        clr_pulse = clr;
        @(negedge clk);
        clr_pulse = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [5:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear(input logic [4:0] m);
        @(negedge clk);
        clr_pulse = m;
        @(negedge clk);
        clr_pulse = '0;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        wait_neg(3);
        chk("R1 flags in reset", flags, 0);
        chk("R1 irq in reset", irq_req, 0);
        rst_n = 1'b1;
        wait_neg(4);
        chk("R1 flags after reset", flags, 0);

        // table: default config (rising, enables off)
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][15:10], VEC[v][9:5]);
            chk($sformatf("R%0d vector %0d", VEC[v][19:16], v), flags, VEC[v][4:0]);
            chk($sformatf("R1 enables default off, vector %0d", v), irq_req, 0);
        end
        step(6'b000111, 5'b00000);
        chk("R5 keys rise ignored", flags, 0);

        // R2 / R11 / R12: pick line on falling edges, enables on
        cfg_write(6'b111_0_1_0);
        step(6'b100111, 5'b00000);
        chk("R2 falling mode ignores rise", flags, 0);
        step(6'b000111, 5'b00000);
        chk("R2 falling mode sets", flags, 5'b00010);
        chk("R11 enabled request", irq_req, 3'b010);
        cfg_write(6'b101_0_1_0);
        chk("R12 enable change next edge", irq_req, 3'b000);
        chk("R11 flag kept when masked", flags, 5'b00010);
        clear(5'b00010);
        chk("R9 clear pick", flags, 0);

        // R10: edge on both-edge line in the clear cycle
        @(negedge clk);
        pin_both = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr_pulse = 5'b00100;
        @(negedge clk);
        clr_pulse = '0;
        chk("R10 set beats clear", flags, 5'b00100);
        clear(5'b00100);
        chk("R9 clear both", flags, 0);

        // R6: long filter width
        cfg_write(6'b001_1_0_0);
        @(negedge clk);
        pin_filt = 1'b1;
        wait_neg(127);
        pin_filt = 1'b0;
        wait_neg(140);
        chk("R6 127-clock pulse ignored", flags, 0);
        @(negedge clk);
        pin_filt = 1'b1;
        wait_neg(128);
        pin_filt = 1'b0;
        wait_neg(2);
        chk("R6 not yet at edge 130", flags, 0);
        wait_neg(1);
        chk("R6 flag at edge 131", flags, 5'b00001);
        chk("R11 filtered request", irq_req, 3'b001);
        wait_neg(300);
        chk("R6 falling level ignored in rising mode", flags, 5'b00001);
        clear(5'b00001);
        chk("R9 clear filtered", flags, 0);

        // R7: short filter width
        cfg_write(6'b001_0_0_0);
        @(negedge clk);
        pin_filt = 1'b1;
        @(negedge clk);
        pin_filt = 1'b0;
        wait_neg(12);
        chk("R7 one-clock pulse ignored", flags, 0);
        pin_filt = 1'b1;
        wait_neg(20);
        chk("R7 held level accepted", flags, 5'b00001);
        clear(5'b00001);

        // R8: filtered line on falling edge
        cfg_write(6'b001_0_0_1);
        chk("R8 no flag before fall", flags, 0);
        pin_filt = 1'b0;
        wait_neg(20);
        chk("R8 falling edge sets", flags, 5'b00001);
        chk("R11 request follows", irq_req, 3'b001);

        finish_run();
    end
endmodule